// File: doc/BRIEF.md
# NAND Flash Page Read Sequencer

This block fetches one raw page, spare bytes included, from an asynchronous 8-bit parallel NAND flash device. The host presents a page (row) address, a starting column and a byte count, then pulses `start`. The block selects the device and writes the read-setup command, the column and row address bytes, and the read-go command. It then waits for the device's ready/busy line to report ready, and strobes the page bytes out one at a time onto a valid/ready byte stream.

The widths of the write-strobe and read-strobe phases come in as cycle counts, so one instance can meet the timing of slow and fast parts. A busy-wait limit guards against a device that never becomes ready. When that limit expires the read is abandoned, the device is deselected and a sticky error flag is raised. The next accepted `start` clears the flag. The host then sends the stream bytes on, for example to a serial link.

Top module: `nand_page_reader`

## Requirements
- R1: While idle, the block holds chip select (`nand_ce_n`), write strobe (`nand_we_n`) and read strobe (`nand_re_n`) high. It holds command latch (`nand_cle`), address latch (`nand_ale`), `busy` and `m_valid` low.
- R2: A read writes exactly seven bytes with strobe pulses. The first is command 0x00 and the seventh is command 0x30. Each command byte is written with `nand_cle`=1 and `nand_ale`=0, and is latched on the rising edge of `nand_we_n`.
- R3: Bytes two to six are address bytes, written with `nand_ale`=1 and `nand_cle`=0. They come in this order: column bits [7:0], column bits [15:8], row bits [7:0], row bits [15:8], row bits [23:16].
- R4: Each write-strobe low phase lasts exactly max(`we_low_cyc`,2) clock cycles. Each high phase between two write strobes lasts exactly max(`we_high_cyc`,2) cycles.
- R5: No read strobe falls until the device's ready/busy line has been seen high after the read-go command. The line passes through a two-stage synchronizer first.
- R6: Exactly `byte_count` bytes are delivered, in column order starting at `col_addr`. Counts up to 65535 are allowed, which covers a 16 KB page plus spare. Each byte is sampled while `nand_re_n` is low. Each read-strobe low phase lasts exactly max(`re_low_cyc`,2) cycles. Each high phase between read strobes lasts at least max(`re_high_cyc`,2) cycles, and exactly that when the sink is always ready. The block leaves the bus undriven during the read.
- R7: While `m_valid`=1 and `m_ready`=0, `m_valid` stays high and `m_data` holds its value. No further read strobe is issued until the pending byte is taken.
- R8: From an accepted start until the final byte is taken, `nand_ce_n` is 0. `nand_wp_n` is 0 whenever the block is active. After the final byte, `done` pulses for one cycle with `nand_ce_n`=1, and the block returns to idle.
- R9: If the device stays busy for more than `busy_timeout` waiting cycles, the read is abandoned. No data strobe is issued, `done` does not pulse, the block returns to idle and `timeout_err` is set. The flag stays set until the next accepted start clears it.
- R10: A `start` pulse while `busy`=1 is ignored. The read in progress keeps the address it was started with.
- R11: With `byte_count`=0, the block still sends the full command and address sequence and waits for ready. It then pulses `done` without any read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a page read (accepted only when idle) |
| row_addr | input | 24 | Page (row) address |
| col_addr | input | 16 | Starting column |
| byte_count | input | 16 | Number of bytes to fetch |
| we_low_cyc | input | 4 | Write-strobe low time in cycles (minimum 2 applied) |
| we_high_cyc | input | 4 | Write-strobe high time in cycles (minimum 2 applied) |
| re_low_cyc | input | 4 | Read-strobe low time in cycles (minimum 2 applied) |
| re_high_cyc | input | 4 | Read-strobe high time in cycles (minimum 2 applied) |
| busy_timeout | input | 20 | Busy-wait limit in cycles |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle pulse at the end of a successful read |
| timeout_err | output | 1 | Sticky busy-wait timeout flag |
| m_data | output | 8 | Stream byte |
| m_valid | output | 1 | Stream byte valid |
| m_ready | input | 1 | Stream sink ready |
| nand_ce_n | output | 1 | Device chip select, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_rb_n | input | 1 | Device ready/busy, low = busy |
| nand_dq | inout | 8 | Bidirectional data bus |

## Verification
A wrong step in the command-address sequencer shows up at the first rising edge of the write strobe that carries the wrong byte or latch enable. The bench logs all seven latched bytes and compares them, so a bad item index or byte select is seen within about fourteen strobe phases of `start`. A phase timer that counts wrongly shows up as a strobe width that differs from the programmed one on the very next pulse. A fault in the read loop, such as a lost decrement, a skipped capture or a second strobe under backpressure, shows up as a wrong byte count, an out-of-order byte or a changed `m_data` while the sink stalls. Each of these is visible on the byte where it happens. A busy wait that never ends, or never times out, is caught because `busy` fails to drop.

// File: rtl/nand_rd_pkg.sv
// Shared constants and state encoding for the NAND page read sequencer.
// Assumes an 8-bit device that uses a two-command page read.
package nand_rd_pkg;

    localparam logic [7:0] CMD_RD_SETUP = 8'h00;
    localparam logic [7:0] CMD_RD_GO    = 8'h30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WE_LO,
        ST_WE_HI,
        ST_WAIT,
        ST_RE_LO,
        ST_RE_HI,
        ST_DONE
    } rd_state_e;

endpackage

// File: rtl/nand_rb_sync.sv
// Ready/busy synchronizer: brings the asynchronous device ready line into
// the clock domain through a chain of STAGES flops.
// Assumes STAGES >= 2. Reset value reads as busy.
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    output logic rb_ready
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], rb_async};
    end

    assign rb_ready = chain_q[STAGES-1];

endmodule

// File: rtl/nand_phase_timer.sv
// Phase timer: counts the cycles of one strobe phase.
// last_o is high on the final cycle of a phase of max(len_cfg,2) cycles.
// Assumes the controller raises clr on every phase change and while untimed.
module nand_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] len_cfg,
    output logic         last_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] eff_len;

    // Apply the two-cycle minimum to the programmed length.
    always_comb eff_len = (len_cfg < W'(2)) ? W'(2) : len_cfg;

    assign last_o = (cnt_q == eff_len - W'(1));

    // Count up within a phase and restart on clr.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr)     cnt_q <= '0;
        else if (!last_o) cnt_q <= cnt_q + W'(1);
    end

endmodule

// File: rtl/nand_cycle_byte.sv
// Bus byte selector for the write sequence. It maps a sequence index to the
// byte and latch enables to present. Order: setup command, column bytes
// (low first), row bytes (low first), go command.
// Assumes COL_W <= 8*COL_BYTES and ROW_W <= 8*ROW_BYTES.
module nand_cycle_byte
    import nand_rd_pkg::*;
#(
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 3,
    parameter int COL_W     = 16,
    parameter int ROW_W     = 24,
    parameter int IDX_W     = 3
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    output logic [7:0]       byte_o,
    output logic             cle_o,
    output logic             ale_o,
    output logic             last_o
);

    localparam int ADDR_CYC = COL_BYTES + ROW_BYTES;
    localparam int NITEMS   = ADDR_CYC + 2;
    localparam int CP_W     = 8 * COL_BYTES;
    localparam int RP_W     = 8 * ROW_BYTES;

    logic [CP_W-1:0] col_pad;
    logic [RP_W-1:0] row_pad;
    logic [7:0]      seq [NITEMS];

    assign col_pad = CP_W'(col);
    assign row_pad = RP_W'(row);

    assign seq[0]        = CMD_RD_SETUP;
    assign seq[NITEMS-1] = CMD_RD_GO;

    // One sequence slot per column address byte.
    for (genvar gi = 0; gi < COL_BYTES; gi++) begin : g_col
        assign seq[1 + gi] = col_pad[8*gi +: 8];
    end

    // One sequence slot per row address byte.
    for (genvar gj = 0; gj < ROW_BYTES; gj++) begin : g_row
        assign seq[1 + COL_BYTES + gj] = row_pad[8*gj +: 8];
    end

    // Decode the index into a byte and the latch enables.
    always_comb begin
        byte_o = '0;
        cle_o  = 1'b0;
        ale_o  = 1'b0;
        last_o = (int'(idx) == NITEMS - 1);
        if (int'(idx) < NITEMS) begin
            byte_o = seq[idx];
            cle_o  = (idx == '0) || (int'(idx) == NITEMS - 1);
            ale_o  = (idx != '0) && (int'(idx) < NITEMS - 1);
        end
    end

endmodule

// File: rtl/nand_page_reader.sv
// NAND page read sequencer top. On start it selects the device and writes
// the setup command, the address bytes and the go command. It then waits
// for ready, with a timeout, and strobes byte_count bytes onto a
// valid/ready stream.
// Assumes the device pulls ready/busy low within one write-strobe high
// phase after the go command. Strobe timing inputs are held stable while
// busy. Outputs are decoded from registered state.
module nand_page_reader
    import nand_rd_pkg::*;
#(
    parameter int ROW_W       = 24,
    parameter int COL_W       = 16,
    parameter int CNT_W       = 16,
    parameter int TW_W        = 4,
    parameter int TO_W        = 20,
    parameter int COL_BYTES   = 2,
    parameter int ROW_BYTES   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [COL_W-1:0] col_addr,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [TW_W-1:0]  we_low_cyc,
    input  logic [TW_W-1:0]  we_high_cyc,
    input  logic [TW_W-1:0]  re_low_cyc,
    input  logic [TW_W-1:0]  re_high_cyc,
    input  logic [TO_W-1:0]  busy_timeout,
    output logic             busy,
    output logic             done,
    output logic             timeout_err,
    output logic [7:0]       m_data,
    output logic             m_valid,
    input  logic             m_ready,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic             nand_wp_n,
    input  logic             nand_rb_n,
    inout  wire  [7:0]       nand_dq
);

    localparam int NITEMS = COL_BYTES + ROW_BYTES + 2;
    localparam int IDX_W  = $clog2(NITEMS);

    rd_state_e        state_q, state_d;
    logic [IDX_W-1:0] item_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [CNT_W-1:0] left_q;
    logic [TO_W-1:0]  wait_q;
    logic [7:0]       data_q;
    logic             oval_q;
    logic             err_q;

    logic             rb_ready;
    logic             t_last;
    logic             t_clr;
    logic [TW_W-1:0]  t_len;
    logic [7:0]       seq_byte;
    logic             seq_cle;
    logic             seq_ale;
    logic             seq_last;
    logic             drive_bus;
    logic             give_up;

    nand_rb_sync #(.STAGES(SYNC_STAGES)) rb_sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_async (nand_rb_n),
        .rb_ready (rb_ready)
    );

    nand_phase_timer #(.W(TW_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (t_clr),
        .len_cfg (t_len),
        .last_o  (t_last)
    );

    nand_cycle_byte #(
        .COL_BYTES (COL_BYTES),
        .ROW_BYTES (ROW_BYTES),
        .COL_W     (COL_W),
        .ROW_W     (ROW_W),
        .IDX_W     (IDX_W)
    ) seq_i (
        .idx    (item_q),
        .col    (col_q),
        .row    (row_q),
        .byte_o (seq_byte),
        .cle_o  (seq_cle),
        .ale_o  (seq_ale),
        .last_o (seq_last)
    );

    assign give_up = (state_q == ST_WAIT) && !rb_ready && (wait_q >= busy_timeout);

    // Pick the programmed length of the current strobe phase.
    always_comb begin
        case (state_q)
            ST_WE_HI: t_len = we_high_cyc;
            ST_RE_LO: t_len = re_low_cyc;
            ST_RE_HI: t_len = re_high_cyc;
            default:  t_len = we_low_cyc;
        endcase
    end

    // Next-state logic of the read sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start) state_d = ST_WE_LO;
            ST_WE_LO: if (t_last) state_d = ST_WE_HI;
            ST_WE_HI: if (t_last) state_d = seq_last ? ST_WAIT : ST_WE_LO;
            ST_WAIT: begin
                if (rb_ready)     state_d = (left_q == '0) ? ST_DONE : ST_RE_LO;
                else if (give_up) state_d = ST_IDLE;
            end
            ST_RE_LO: if (t_last) state_d = ST_RE_HI;
            ST_RE_HI: begin
                if (t_last && (!oval_q || m_ready))
                    state_d = (left_q == '0) ? ST_DONE : ST_RE_LO;
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Restart the phase timer on every change and in untimed states.
    always_comb begin
        t_clr = (state_d != state_q) ||
                (state_q == ST_IDLE) || (state_q == ST_WAIT) || (state_q == ST_DONE);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request and step through the write sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            item_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            row_q  <= row_addr;
            col_q  <= col_addr;
            item_q <= '0;
        end else if (state_q == ST_WE_HI && t_last && !seq_last) begin
            item_q <= item_q + IDX_W'(1);
        end
    end

    // Busy-wait cycle counter, cleared outside the wait state.
    always_ff @(posedge clk) begin
        if (!rst_n)                                wait_q <= '0;
        else if (state_q == ST_WAIT && !give_up)   wait_q <= wait_q + TO_W'(1);
        else                                       wait_q <= '0;
    end

    // Sticky timeout flag, cleared by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                            err_q <= 1'b0;
        else if (state_q == ST_IDLE && start)  err_q <= 1'b0;
        else if (give_up)                      err_q <= 1'b1;
    end

    // Remaining byte counter, loaded at start and decremented per capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                              left_q <= '0;
        else if (state_q == ST_IDLE && start)    left_q <= byte_count;
        else if (state_q == ST_RE_LO && t_last)  left_q <= left_q - CNT_W'(1);
    end

    // Sample the bus at the end of the read-strobe low phase and hold it
    // on the stream until the sink takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            oval_q <= 1'b0;
        end else if (state_q == ST_RE_LO && t_last) begin
            data_q <= nand_dq;
            oval_q <= 1'b1;
        end else if (oval_q && m_ready) begin
            oval_q <= 1'b0;
        end
    end

    assign drive_bus   = (state_q == ST_WE_LO) || (state_q == ST_WE_HI);
    assign nand_dq     = drive_bus ? seq_byte : 8'bz;
    assign nand_cle    = drive_bus && seq_cle;
    assign nand_ale    = drive_bus && seq_ale;
    assign nand_we_n   = (state_q != ST_WE_LO);
    assign nand_re_n   = (state_q != ST_RE_LO);
    assign nand_ce_n   = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign nand_wp_n   = 1'b0;
    assign busy        = (state_q != ST_IDLE);
    assign done        = (state_q == ST_DONE);
    assign timeout_err = err_q;
    assign m_data      = data_q;
    assign m_valid     = oval_q;

endmodule

// File: rtl/nand_page_reader_chk.sv
// Checker for nand_page_reader: port-level temporal properties, bound to
// every instance of the top module.
module nand_page_reader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       timeout_err,
    input logic [7:0] m_data,
    input logic       m_valid,
    input logic       m_ready,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_wp_n,
    input logic       nand_rb_n
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !m_valid));

    a_r2_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    a_r4_we_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> !$past(nand_we_n, 2));

    a_r5_ready_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_re_n) |-> $past(nand_rb_n));

    a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    a_r7_no_strobe_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> nand_re_n);

    a_r8_ce_active: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> (!nand_ce_n && !nand_wp_n));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_err && !(start && !busy)) |=> timeout_err);

    a_r9_err_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (!busy && !done));

endmodule

bind nand_page_reader nand_page_reader_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .m_data      (m_data),
    .m_valid     (m_valid),
    .m_ready     (m_ready),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_wp_n   (nand_wp_n),
    .nand_rb_n   (nand_rb_n)
);

// File: tb/nand_page_reader_tb_top.sv
// Bench for nand_page_reader: a behavioural NAND device model, a random-
// ready stream sink and port monitors. Mixes directed and seeded random
// reads.
module nand_page_reader_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] row_addr = '0;
    logic [15:0] col_addr = '0;
    logic [15:0] byte_count = '0;
    logic [3:0]  we_low_cyc = '0, we_high_cyc = '0, re_low_cyc = '0, re_high_cyc = '0;
    logic [19:0] busy_timeout = '0;
    logic        busy, done, timeout_err, m_valid;
    logic [7:0]  m_data;
    logic        m_ready = 1'b0;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n;
    logic        nand_rb_n = 1'b1;
    wire  [7:0]  nand_dq;

    always #2.5 clk = ~clk;

    nand_page_reader dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .row_addr(row_addr),
        .col_addr(col_addr), .byte_count(byte_count), .we_low_cyc(we_low_cyc),
        .we_high_cyc(we_high_cyc), .re_low_cyc(re_low_cyc), .re_high_cyc(re_high_cyc),
        .busy_timeout(busy_timeout), .busy(busy), .done(done), .timeout_err(timeout_err),
        .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n), .nand_rb_n(nand_rb_n),
        .nand_dq(nand_dq)
    );

    // Page content of the device model and expected stream content.
    function automatic logic [7:0] pat(input logic [23:0] r, input logic [15:0] c);
        return r[7:0] ^ r[15:8] ^ r[23:16] ^ c[7:0] ^ {c[11:8], c[15:12]} ^ 8'h5A;
    endfunction

    function automatic int eff(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    int tests = 0, fails = 0, cyc = 0;

    // Per-run configuration seen by the monitor.
    int cfg_wl, cfg_wh, cfg_rl, cfg_rh, cfg_blen, cfg_rpct;
    logic [23:0] exp_row;
    logic [15:0] exp_col;

    // Monitor and model state.
    logic [9:0]  log_e [16];
    int          log_n, addr_pos, busy_cnt, rd_idx;
    logic [23:0] mdl_row;
    logic [15:0] mdl_col;
    logic        prev_we, prev_re, we_seen, re_seen, prev_pend;
    logic [7:0]  prev_data;
    int          we_lo_run, we_hi_run, re_lo_run, re_hi_run;
    int          we_err, re_err, rb_err, stab_err, ce_err, data_err;
    int          nbytes, re_pulses, dcount;

    assign nand_dq = nand_re_n ? 8'bz : pat(mdl_row, mdl_col + rd_idx[15:0]);

    // Watchdog: a hung run ends as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            $display("FAIL watchdog: act=%0d cycles exp<190000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
            $finish;
        end
    end

    // Device model, stream sink and port monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (start && !busy) begin
            log_n = 0; addr_pos = 0; busy_cnt = 0; rd_idx = 0; nand_rb_n = 1'b1;
            prev_we = 1'b1; prev_re = 1'b1; we_seen = 1'b0; re_seen = 1'b0;
            prev_pend = 1'b0; we_lo_run = 0; we_hi_run = 0; re_lo_run = 0; re_hi_run = 0;
            we_err = 0; re_err = 0; rb_err = 0; stab_err = 0; ce_err = 0; data_err = 0;
            nbytes = 0; re_pulses = 0; dcount = 0; mdl_row = '0; mdl_col = '0;
        end else if (rst_n) begin
            if (busy_cnt > 0) begin
                busy_cnt = busy_cnt - 1;
                if (busy_cnt == 0) nand_rb_n = 1'b1;
            end
            // Write strobe: widths and latched bytes.
            if (!nand_we_n) begin
                if (prev_we && we_seen && we_hi_run != eff(cfg_wh)) we_err++;
                we_lo_run++;
            end else if (!prev_we) begin
                if (we_lo_run != eff(cfg_wl)) we_err++;
                we_lo_run = 0; we_hi_run = 1; we_seen = 1'b1;
                if (log_n < 16) log_e[log_n] = {nand_cle, nand_ale, nand_dq};
                log_n++;
                if (nand_cle && nand_dq == 8'h30) begin
                    busy_cnt = cfg_blen; nand_rb_n = 1'b0; rd_idx = 0;
                end
                if (nand_ale) begin
                    case (addr_pos)
                        0: mdl_col[7:0]    = nand_dq;
                        1: mdl_col[15:8]   = nand_dq;
                        2: mdl_row[7:0]    = nand_dq;
                        3: mdl_row[15:8]   = nand_dq;
                        default: mdl_row[23:16] = nand_dq;
                    endcase
                    addr_pos++;
                end
            end else begin
                we_hi_run++;
            end
            // Read strobe: widths, ready state and byte index.
            if (!nand_re_n) begin
                if (prev_re) begin
                    if (!nand_rb_n) rb_err++;
                    if (re_seen && (re_hi_run < eff(cfg_rh) ||
                        (cfg_rpct >= 100 && re_hi_run != eff(cfg_rh)))) re_err++;
                end
                re_lo_run++;
            end else if (!prev_re) begin
                if (re_lo_run != eff(cfg_rl)) re_err++;
                re_lo_run = 0; re_hi_run = 1; re_seen = 1'b1; re_pulses++; rd_idx++;
            end else begin
                re_hi_run++;
            end
            prev_we = nand_we_n;
            prev_re = nand_re_n;
            // Stream sink.
            if (prev_pend && (!m_valid || m_data != prev_data)) stab_err++;
            m_ready = (($urandom % 100) < cfg_rpct);
            if (m_valid && m_ready) begin
                if (m_data != pat(exp_row, exp_col + nbytes[15:0])) data_err++;
                nbytes++;
            end
            prev_pend = m_valid && !m_ready;
            prev_data = m_data;
            // Chip select, write protect and done.
            if (busy && !done && nand_ce_n) ce_err++;
            if (busy && nand_wp_n) ce_err++;
            if (done) begin
                dcount++;
                if (!nand_ce_n) ce_err++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !busy && !m_valid,
            tag, {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, busy, m_valid}, 7'b1110000);
    endtask

    task automatic run_read(input int row, input int col, input int cnt,
                            input int wl, input int wh, input int rl, input int rh,
                            input int blen, input int tmo, input int rpct,
                            input bit restart, input bit expect_to);
        @(posedge clk); #1;
        cfg_wl = wl; cfg_wh = wh; cfg_rl = rl; cfg_rh = rh; cfg_blen = blen; cfg_rpct = rpct;
        exp_row = row[23:0]; exp_col = col[15:0];
        row_addr = row[23:0]; col_addr = col[15:0]; byte_count = cnt[15:0];
        we_low_cyc = wl[3:0]; we_high_cyc = wh[3:0]; re_low_cyc = rl[3:0]; re_high_cyc = rh[3:0];
        busy_timeout = tmo[19:0];
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (restart) begin
            repeat (3) @(posedge clk);
            #1; row_addr = ~row[23:0]; col_addr = ~col[15:0]; start = 1'b1;
            @(posedge clk); #1; start = 1'b0;
        end
        while (busy) begin
            @(posedge clk); #1;
        end
        @(negedge clk); #1;
        // R2: command bytes and latch enables.
        chk(log_n == 7 && log_e[0] == {2'b10, 8'h00} && log_e[6] == {2'b10, 8'h30},
            "R2 command cycles", log_n, 7);
        // R3: address order and latch enables (R10 when restarted).
        chk(log_e[1] == {2'b01, col[7:0]} && log_e[2] == {2'b01, col[15:8]} &&
            log_e[3] == {2'b01, row[7:0]} && log_e[4] == {2'b01, row[15:8]} &&
            log_e[5] == {2'b01, row[23:16]},
            restart ? "R10 restart ignored, address kept" : "R3 address bytes",
            int'({mdl_row, mdl_col}), int'({row[23:0], col[15:0]}));
        chk(we_err == 0, "R4 write strobe widths", we_err, 0);
        if (expect_to) begin
            chk(timeout_err && dcount == 0 && nbytes == 0 && re_pulses == 0,
                "R9 timeout abort", {timeout_err, dcount[3:0], re_pulses[3:0]}, 9'h100);
        end else begin
            chk(!timeout_err, "R9 flag clear after good start", timeout_err, 0);
            chk(nbytes == cnt && re_pulses == cnt,
                (cnt == 0) ? "R11 zero-length read" : "R6 byte count", nbytes, cnt);
            chk(data_err == 0, "R6 byte data", data_err, 0);
            chk(re_err == 0, "R6 read strobe widths", re_err, 0);
            chk(rb_err == 0, "R5 no strobe while busy", rb_err, 0);
            chk(stab_err == 0, "R7 backpressure hold", stab_err, 0);
            chk(dcount == 1 && ce_err == 0, "R8 select and done", dcount * 100 + ce_err, 100);
        end
        chk_idle("R1 idle after run");
    endtask

    initial begin
        void'($urandom(32'd1234));
        cfg_wl = 2; cfg_wh = 2; cfg_rl = 2; cfg_rh = 2; cfg_blen = 1; cfg_rpct = 100;
        exp_row = '0; exp_col = '0;
        repeat (5) @(posedge clk);
        #1;
        chk_idle("R1 reset state");
        chk(!timeout_err && !done, "R1 reset flags", {timeout_err, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // Directed cases.
        run_read(24'h123456, 16'h0010, 8, 2, 2, 2, 2, 4, 500, 100, 1'b0, 1'b0);
        run_read(24'hABCDEF, 16'h0800, 12, 5, 3, 4, 6, 9, 500, 100, 1'b0, 1'b0); // R4 R6 wide strobes
        run_read(24'h000001, 16'h0000, 0, 0, 1, 0, 0, 6, 500, 100, 1'b0, 1'b0);  // R11
        run_read(24'h0F0F0F, 16'hFFFE, 6, 3, 2, 2, 3, 5, 500, 25, 1'b0, 1'b0);   // R7 stalls
        run_read(24'h777777, 16'h0042, 4, 2, 2, 2, 2, 5000, 40, 100, 1'b0, 1'b1); // R9 timeout
        chk(timeout_err, "R9 flag sticky while idle", timeout_err, 1);
        run_read(24'h246802, 16'h1357, 5, 2, 2, 2, 2, 3, 500, 100, 1'b1, 1'b0);  // R10, R9 clear
        run_read(24'h3C3C3C, 16'h0000, 17664, 0, 0, 0, 0, 20, 500, 100, 1'b0, 1'b0); // R6 16K+spare

        // Seeded random reads.
        for (int k = 0; k < 20; k++) begin
            run_read(int'($urandom % 24'hFFFFFF), int'($urandom % 17'h10000),
                     int'($urandom % 40), int'($urandom % 7), int'($urandom % 7),
                     int'($urandom % 7), int'($urandom % 7), 1 + int'($urandom % 30),
                     300, 30 + int'($urandom % 71), 1'b0, 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule